// File: doc/BRIEF.md
# Cluster Debug Halt Coordinator

This block links the debug halt state of the cores in a small cluster of up to four cores. When one core stops for a debug reason, the other cores can be made to stop with it, so the whole cluster can be inspected at a single point in time. Software configures the block through a one-cycle command port. Each command carries an opcode, a 4-bit parameter and a 32-bit data word. Read commands return a value on a registered readback word.

Three settings decide which halts spread and to where. A receive mask lists the cores that take part in the cluster. A trigger mask lists the cores whose halts may spread. A 4-bit cause enable chooses which halt causes count. Each core reports a halted flag and a 4-bit cause vector. Cause bit 0 is a status-flag halt, bit 1 an actionpoint, bit 2 a breakpoint and bit 3 a self-halt. Software usually adds a core as it comes online by a read-modify-write of the receive mask. It then writes the same core mask into the trigger mask, with all four causes enabled.

The block also holds a 64-bit cluster counter. This counter stands still in any cycle in which a core named in a separate freeze mask is halted.

Top module: `cluster_halt_coord`

## Requirements
- R1: After a synchronous active-low reset, the receive mask, the trigger mask, the cause enable, the freeze mask, `halt_req`, `cluster_count` and `cmd_readback` are all zero.
- R2: Opcode 0x11 writes `cmd_data[3:0]` into the receive mask, and the upper data bits are ignored. Opcode 0x10 loads the receive mask, zero-extended, into `cmd_readback` at the clock edge that accepts the command.
- R3: Opcode 0x13 writes `cmd_data[3:0]` into the trigger mask and `cmd_param` into the cause enable. Opcode 0x12 returns the trigger mask in readback bits [3:0] and the cause enable in bits [11:8], with all other bits zero.
- R4: Opcode 0x21 writes `cmd_data[3:0]` into the freeze mask. Opcode 0x20 returns the freeze mask in readback bits [3:0].
- R5: A core is a trigger when it is halted, is set in both the receive mask and the trigger mask, and shares at least one set bit between its cause vector and the cause enable. One clock edge after a trigger appears, `halt_req` is set for every other core in the receive mask. A core is never requested by its own trigger alone.
- R6: `halt_req` stays set for as long as the triggering core stays a trigger. It clears at the first edge after the trigger ends.
- R7: A halted core whose cause bits are all disabled causes no halt request.
- R8: A core that is not in the receive mask never triggers a halt request and never receives one.
- R9: `cluster_count` increases by one at every edge where no core in the freeze mask is halted. It holds its value at any edge where such a core is halted. Halted cores outside the freeze mask have no effect on it.
- R10: A configuration write applies from the edge after it is accepted. A halt that is present in the same cycle as the write is judged against the old setting at that edge.
- R11: A command with an unknown opcode changes no setting and leaves `cmd_readback` unchanged. `cmd_readback` also holds its value in every cycle that has no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_param | input | 4 | Command parameter (cause enable for opcode 0x13) |
| cmd_data | input | 32 | Command write data |
| cmd_readback | output | 32 | Value returned by the last read command |
| core_halted | input | 4 | Per-core halted flag |
| core_cause | input | 16 | Per-core 4-bit halt cause, core i in bits [4i+3:4i] |
| halt_req | output | 4 | Per-core halt request to the cluster |
| cluster_count | output | 64 | Shared cluster counter |

## Verification
Two functions can act on the same edge: a configuration write and a halt decision that depends on that same setting. The bench provokes this in two ways. In the first, a cause-enable write arrives in the cycle in which a core halts with a cause that the write newly enables. In the second, a freeze-mask write arrives while a core that the write adds is already halted. The bench requires the old setting to decide the first edge and the new setting to decide the next one. A reference count for the counter, built from the driven inputs, judges the freeze case.

// File: rtl/chc_pkg.sv
// Package: shared constants for the cluster debug halt coordinator.
// Assumes: opcode values are fixed here; each block decodes them from this package.
package chc_pkg;
    localparam int unsigned OP_W      = 8;
    localparam int unsigned CAUSE_W   = 4;
    localparam int unsigned CAUSE_LSB = 8;   // cause enable position in the trigger readback

    typedef enum logic [OP_W-1:0] {
        OP_RECV_RD = 8'h10,
        OP_RECV_WR = 8'h11,
        OP_TRIG_RD = 8'h12,
        OP_TRIG_WR = 8'h13,
        OP_FRZ_RD  = 8'h20,
        OP_FRZ_WR  = 8'h21
    } chc_op_e;
endpackage

// File: rtl/chc_cfg_regs.sv
// Module: command decode and configuration storage.
// Holds the receive, trigger and freeze masks and the cause enable, and returns
// them on a registered readback word in response to read commands.
// Assumes: N_CORES <= CAUSE_LSB and N_CORES < DATA_W; one command per cycle.
module chc_cfg_regs
    import chc_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [CAUSE_W-1:0]  cmd_param,
    input  logic [DATA_W-1:0]   cmd_data,
    output logic [N_CORES-1:0]  recv_mask,
    output logic [N_CORES-1:0]  trig_mask,
    output logic [CAUSE_W-1:0]  cause_en,
    output logic [N_CORES-1:0]  frz_mask,
    output logic [DATA_W-1:0]   readback
);
    logic [DATA_W-1:0] rd_value;
    logic              rd_hit;
    logic              unused_data_hi;

    assign unused_data_hi = ^cmd_data[DATA_W-1:N_CORES];

    // Select the value a read command returns.
    always_comb begin
        rd_value = '0;
        rd_hit   = 1'b0;
        case (cmd_op)
            OP_RECV_RD: begin
                rd_value[N_CORES-1:0] = recv_mask;
                rd_hit                = 1'b1;
            end
            OP_TRIG_RD: begin
                rd_value[N_CORES-1:0]           = trig_mask;
                rd_value[CAUSE_LSB +: CAUSE_W]  = cause_en;
                rd_hit                          = 1'b1;
            end
            OP_FRZ_RD: begin
                rd_value[N_CORES-1:0] = frz_mask;
                rd_hit                = 1'b1;
            end
            default: ;
        endcase
    end

    // Apply write commands to the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recv_mask <= '0;
            trig_mask <= '0;
            cause_en  <= '0;
            frz_mask  <= '0;
        end else if (cmd_valid) begin
            case (cmd_op)
                OP_RECV_WR: recv_mask <= cmd_data[N_CORES-1:0];
                OP_TRIG_WR: begin
                    trig_mask <= cmd_data[N_CORES-1:0];
                    cause_en  <= cmd_param;
                end
                OP_FRZ_WR:  frz_mask  <= cmd_data[N_CORES-1:0];
                default: ;
            endcase
        end
    end

    // Capture the readback word on read commands; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            readback <= '0;
        else if (cmd_valid && rd_hit)
            readback <= rd_value;
    end
endmodule

// File: rtl/chc_halt_fanout.sv
// Module: halt trigger detection and registered fan-out of halt requests.
// A core triggers when it is halted, is set in both masks and has an enabled cause.
// Each core in the receive mask is requested when any other core triggers.
// Assumes: the core holds its cause vector stable while it stays halted.
module chc_halt_fanout
    import chc_pkg::*;
#(
    parameter int unsigned N_CORES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES-1:0]          recv_mask,
    input  logic [N_CORES-1:0]          trig_mask,
    input  logic [CAUSE_W-1:0]          cause_en,
    input  logic [N_CORES-1:0]          core_halted,
    input  logic [N_CORES*CAUSE_W-1:0]  core_cause,
    output logic [N_CORES-1:0]          halt_req
);
    logic [N_CORES-1:0] fire;
    logic [N_CORES-1:0] req_next;

    for (genvar gi = 0; gi < N_CORES; gi++) begin : g_fire
        // Decide whether core gi is a trigger this cycle.
        always_comb begin
            fire[gi] = recv_mask[gi] && trig_mask[gi] && core_halted[gi]
                       && |(core_cause[gi*CAUSE_W +: CAUSE_W] & cause_en);
        end
    end

    for (genvar gj = 0; gj < N_CORES; gj++) begin : g_req
        localparam logic [N_CORES-1:0] SELF = N_CORES'(1) << gj;
        // Request core gj when a different core triggers.
        always_comb begin
            req_next[gj] = recv_mask[gj] && |(fire & ~SELF);
        end
    end

    // Register the requests so that they reach the cores one edge after the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_req <= '0;
        else
            halt_req <= req_next;
    end
endmodule

// File: rtl/chc_cluster_counter.sv
// Module: shared cluster counter with a halt-controlled freeze.
// Counts each cycle unless a core named in the freeze mask is halted.
// Assumes: the count wraps silently at 2**CNT_W.
module chc_cluster_counter #(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned CNT_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] frz_mask,
    input  logic [N_CORES-1:0] core_halted,
    output logic [CNT_W-1:0]   count
);
    logic freeze;

    // Freeze whenever a watched core is halted.
    always_comb begin
        freeze = |(frz_mask & core_halted);
    end

    // Advance the count on every edge that is not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (!freeze)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/cluster_halt_coord.sv
// Module: top of the cluster debug halt coordinator.
// Connects the command decoder, the halt fan-out and the cluster counter.
// Assumes: a single clock domain; core halt and cause inputs are synchronous to clk.
module cluster_halt_coord
    import chc_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [OP_W-1:0]             cmd_op,
    input  logic [CAUSE_W-1:0]          cmd_param,
    input  logic [DATA_W-1:0]           cmd_data,
    output logic [DATA_W-1:0]           cmd_readback,
    input  logic [N_CORES-1:0]          core_halted,
    input  logic [N_CORES*CAUSE_W-1:0]  core_cause,
    output logic [N_CORES-1:0]          halt_req,
    output logic [CNT_W-1:0]            cluster_count
);
    logic [N_CORES-1:0] recv_mask;
    logic [N_CORES-1:0] trig_mask;
    logic [CAUSE_W-1:0] cause_en;
    logic [N_CORES-1:0] frz_mask;

    chc_cfg_regs #(.N_CORES(N_CORES), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_param (cmd_param),
        .cmd_data  (cmd_data),
        .recv_mask (recv_mask),
        .trig_mask (trig_mask),
        .cause_en  (cause_en),
        .frz_mask  (frz_mask),
        .readback  (cmd_readback)
    );

    chc_halt_fanout #(.N_CORES(N_CORES)) u_fanout (
        .clk         (clk),
        .rst_n       (rst_n),
        .recv_mask   (recv_mask),
        .trig_mask   (trig_mask),
        .cause_en    (cause_en),
        .core_halted (core_halted),
        .core_cause  (core_cause),
        .halt_req    (halt_req)
    );

    chc_cluster_counter #(.N_CORES(N_CORES), .CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .frz_mask    (frz_mask),
        .core_halted (core_halted),
        .count       (cluster_count)
    );
endmodule

// File: rtl/chc_checker.sv
// Module: property checker for the cluster debug halt coordinator, bound to the top.
// Assumes: it observes the top's ports and its internal configuration masks.
module chc_checker #(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [N_CORES-1:0] core_halted,
    input logic [N_CORES-1:0] halt_req,
    input logic [CNT_W-1:0]   cluster_count,
    input logic [DATA_W-1:0]  cmd_readback,
    input logic [N_CORES-1:0] recv_mask,
    input logic [N_CORES-1:0] frz_mask
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (halt_req == '0 && cluster_count == '0 && cmd_readback == '0));

    p_req_needs_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(core_halted) == '0) |-> halt_req == '0);

    p_req_only_recv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (halt_req & ~$past(recv_mask)) == '0);

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(|(frz_mask & core_halted)))
        |-> cluster_count == $past(cluster_count) + CNT_W'(1));

    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|(frz_mask & core_halted))) |-> $stable(cluster_count));

    p_rb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cmd_valid)) |-> $stable(cmd_readback));
endmodule

bind cluster_halt_coord chc_checker #(
    .N_CORES(N_CORES), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .core_halted   (core_halted),
    .halt_req      (halt_req),
    .cluster_count (cluster_count),
    .cmd_readback  (cmd_readback),
    .recv_mask     (recv_mask),
    .frz_mask      (frz_mask)
);

// File: tb/test_cluster_halt_coord.sv
`timescale 1ns/1ps
module test_cluster_halt_coord;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [3:0]  cmd_param = '0;
    logic [31:0] cmd_data = '0;
    logic [31:0] cmd_readback;
    logic [N-1:0]   core_halted = '0;
    logic [4*N-1:0] core_cause = '0;
    logic [N-1:0]   halt_req;
    logic [63:0]    cluster_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 readback, 1 halt_req, 2 count
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [63:0] m_cnt = '0;
    logic [N-1:0] m_frz = '0;

    always #4 clk = ~clk;

    cluster_halt_coord i_cluster_halt_coord (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_param(cmd_param), .cmd_data(cmd_data), .cmd_readback(cmd_readback),
        .core_halted(core_halted), .core_cause(core_cause),
        .halt_req(halt_req), .cluster_count(cluster_count)
    );

    // Reference count for R9, built from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0;
            m_frz = '0;
        end else begin
            if ((m_frz & core_halted) == '0) m_cnt = m_cnt + 64'd1;
            if (cmd_valid && cmd_op == 8'h21) m_frz = cmd_data[N-1:0];
        end
    end

    // Monitor: pop expected items and compare them away from the clock edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = {32'd0, cmd_readback};
                1: act = {60'd0, halt_req};
                default: act = cluster_count;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int kind, logic [63:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic issue(logic [7:0] op, logic [3:0] prm, logic [31:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_param = prm;
        cmd_data  = data;
        tick();
        cmd_valid = 1'b0;
        cmd_op    = '0;
        cmd_data  = '0;
        cmd_param = '0;
    endtask

    task automatic halt(int core, logic [3:0] cause);
        core_halted[core] = 1'b1;
        core_cause[core*4 +: 4] = cause;
    endtask

    task automatic release_all();
        core_halted = '0;
        core_cause  = '0;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rmw;
        repeat (3) tick();
        push(0, 64'h0, "R1 readback after reset");
        push(1, 64'h0, "R1 halt_req after reset");
        push(2, 64'h0, "R1 count after reset");
        rst_n = 1'b1;
        issue(8'h10, 4'h0, 32'h0); push(0, 64'h0, "R1 receive mask reset");
        issue(8'h12, 4'h0, 32'h0); push(0, 64'h0, "R1 trigger mask reset");
        issue(8'h20, 4'h0, 32'h0); push(0, 64'h0, "R1 freeze mask reset");

        // R2: receive mask write, upper data ignored, then read-modify-write
        issue(8'h11, 4'h0, 32'hFFFF_FFF5);
        issue(8'h10, 4'h0, 32'h0); push(0, 64'h5, "R2 receive mask upper bits dropped");
        @(negedge clk);
        rmw = cmd_readback | 32'h2;
        tick();
        issue(8'h11, 4'h0, rmw);
        issue(8'h10, 4'h0, 32'h0); push(0, 64'h7, "R2 receive mask after read-modify-write");

        // R3: trigger mask with breakpoint cause only
        issue(8'h13, 4'h4, 32'h7);
        issue(8'h12, 4'h0, 32'h0); push(0, 64'h407, "R3 trigger readback");

        // R11: unknown opcode, then idle cycles, leave all unchanged
        issue(8'h3F, 4'hF, 32'hFFFF_FFFF); push(0, 64'h407, "R11 readback after unknown op");
        tick(); push(0, 64'h407, "R11 readback idle");
        issue(8'h10, 4'h0, 32'h0); push(0, 64'h7, "R11 receive mask after unknown op");

        // R7: halt with a disabled cause
        halt(0, 4'h1);
        tick(); tick(); push(1, 64'h0, "R7 disabled cause no request");

        // R5: enabled cause, one cycle latency, not to self, not to core 3
        halt(0, 4'h4);
        push(1, 64'h0, "R5 no request in the halt cycle");
        tick(); push(1, 64'h6, "R5 request one edge after trigger");
        // R6: held while halted
        tick(); tick(); push(1, 64'h6, "R6 request held while halted");
        release_all();
        push(1, 64'h6, "R6 request still set in release cycle");
        tick(); push(1, 64'h0, "R6 request drops after release");

        // R8: unselected core never triggers
        halt(3, 4'hF);
        tick(); tick(); push(1, 64'h0, "R8 unselected core does not trigger");
        release_all();

        // R5: two triggers request each other
        halt(1, 4'h4); halt(2, 4'h4);
        tick(); push(1, 64'h7, "R5 two triggers");
        release_all(); tick();

        // R3: core in receive mask but not in trigger mask does not trigger
        issue(8'h13, 4'h4, 32'h1);
        halt(1, 4'hF);
        tick(); tick(); push(1, 64'h0, "R3 non-trigger core ignored");
        release_all(); tick();

        // R10: cause enable write in the cycle core 0 halts with status-flag cause
        issue(8'h13, 4'h4, 32'h7);
        halt(0, 4'h1);
        cmd_valid = 1'b1; cmd_op = 8'h13; cmd_param = 4'hF; cmd_data = 32'h7;
        tick();
        cmd_valid = 1'b0; cmd_op = '0; cmd_param = '0; cmd_data = '0;
        push(1, 64'h0, "R10 old cause enable at write edge");
        tick(); push(1, 64'h6, "R10 new cause enable next edge");
        release_all(); tick();

        // R4: freeze mask set and read
        issue(8'h21, 4'h0, 32'hFFFF_FFF2);
        issue(8'h20, 4'h0, 32'h0); push(0, 64'h2, "R4 freeze mask readback");

        // R9: counting, freezing, halted cores outside the mask
        tick(); push(2, m_cnt, "R9 counting while no watched halt");
        halt(0, 4'h0);
        tick(); tick(); push(2, m_cnt, "R9 core outside freeze mask");
        halt(1, 4'h0);
        tick(); push(2, m_cnt, "R9 frozen first edge");
        tick(); tick(); push(2, m_cnt, "R9 still frozen");
        release_all();
        tick(); push(2, m_cnt, "R9 resumes");

        // R10: freeze mask write while the newly added core is already halted
        halt(2, 4'h0);
        cmd_valid = 1'b1; cmd_op = 8'h21; cmd_data = 32'h4;
        tick();
        cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
        push(2, m_cnt, "R10 counter uses old freeze mask at write edge");
        tick(); push(2, m_cnt, "R10 counter frozen by new mask");
        release_all();
        tick(); push(2, m_cnt, "R9 counting after freeze ends");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule